// File: doc/BRIEF.md
# PCI Configuration Access Unit

This block gives a host a hardware path into the configuration headers of a small set of on-chip PCI functions. It follows the address-port/data-port access scheme. The host first writes a 32-bit target address into an address port. That address selects a bus, a device, a function and a dword register. The host then moves 1, 2 or 4 bytes through a four-lane data window. The lane index is the data port number minus the window's first port, which is 0xCFC in the conventional port map.

Each populated device keeps its header in a register array. Identification dwords hold fixed parameter values. Base address registers (BARs) answer the all-ones sizing probe with a fixed 4 KB mask, and only when the BAR is populated. I/O-type BARs always read with bit 0 set. Writes to the expansion ROM base are dropped. Any access to a disabled address, or to a target that does not exist, reads as all ones.

Top module: `pci_cfg_unit`

## Requirements
- R1: A write to the address port (io_data_sel=0) stores all 32 bits of io_wdata. A read of that port returns the stored value. Reset clears the address register and io_rdata to 0.
- R2: The address register fields are: enable in bit 31, bus in bits 23:16, device in bits 15:11, function in bits 10:8 and dword index in bits 7:2. The byte position inside the dword is io_lane.
- R3: While address bit 31 is 0, a data-port read returns 0xFFFFFFFF and a data-port write changes no stored register.
- R4: When the bus is nonzero, the function is nonzero or the device number is NUM_DEV or higher, a data read returns 0xFFFFFFFF and a data write is ignored.
- R5: The following dwords are read-only parameter values:
  - dword 0 (offset 0x00) is {device ID, vendor ID};
  - dword 2 (offset 0x08) is {class, subclass, 16'h0000};
  - dword 11 (offset 0x2C) is {subsystem ID, subsystem vendor ID}.
- R6: A 4-byte write (io_size 2 or 3) of 0xFFFFFFFF to dwords 4 to 9 is a sizing probe for BAR index dword-4. It stores 0xFFFFF000 when that index is below the device's BAR count, and 0 otherwise.
- R7: A populated I/O-type BAR always reads with bit 0 = 1, after reset and after any write or probe. Reset clears every other writable dword to 0.
- R8: Writes to dword 12 (offset 0x30, expansion ROM base) are discarded, and that dword reads 0.
- R9: Writes merge into the addressed dword according to io_size:
  - io_size=0: io_wdata[7:0] goes to byte lane io_lane;
  - io_size=1: io_wdata[15:0] goes to bits 15:0 when io_lane=0, otherwise to bits 31:16;
  - io_size=2 or 3: the whole dword is written.
  Dwords 1, 3, 10, 13 to 15 and the BARs are writable. Dwords 16 to 63 read 0 and ignore writes.
- R10: Reads are shaped according to io_size and zero-extended:
  - io_size=0: returns the byte at lane io_lane;
  - io_size=1: returns bits 15:0 when io_lane=0, otherwise bits 31:16;
  - io_size=2 or 3: returns the full dword.
- R11: io_rdata is loaded at the clock edge that accepts a read (io_valid=1, io_write=0), so it is valid one cycle later. At every other edge it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Access strobe, one cycle per access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_data_sel | input | 1 | 0 = address port, 1 = data window |
| io_lane | input | 2 | Data window byte lane (port minus window base) |
| io_size | input | 2 | 0 = byte, 1 = half-word, 2/3 = dword |
| io_wdata | input | 32 | Write data, right-justified for narrow accesses |
| io_rdata | output | 32 | Read data, registered |

## Verification
The bound checker watches several rules on every cycle:
- the address register captures writes and reads back what it holds;
- reads with the enable bit clear, or aimed at a missing bus, function or device, return all ones;
- narrow reads are zero-extended;
- read data holds between reads.

Other rules depend on history held inside a device's header, and only the bench's directed and random sequences, checked against a bench-side model, can show them:
- BAR probe masks and the rule that populated I/O BARs always read with bit 0 set;
- dropped ROM writes and read-only identification dwords;
- byte-lane merging of narrow writes.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

    localparam int HDR_DWORDS   = 16;
    localparam int BAR_SLOTS    = 6;
    localparam int DW_IDS       = 0;
    localparam int DW_CLASS     = 2;
    localparam int DW_BAR_FIRST = 4;
    localparam int DW_BAR_LAST  = DW_BAR_FIRST + BAR_SLOTS - 1;
    localparam int DW_SUBSYS    = 11;
    localparam int DW_ROM       = 12;
    localparam logic [31:0] PROBE_MASK = 32'hFFFF_F000;
    localparam logic [31:0] ALL_ONES   = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_WORD2 = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [5:0] dword;
    } cfg_target_t;

    // byte enables for a narrow or full access at a given lane
    function automatic logic [3:0] lane_be(input logic [1:0] size, input logic [1:0] lane);
        logic [3:0] be;
        case (size)
            2'd0:    be = 4'b0001 << lane;
            2'd1:    be = (lane == 2'd0) ? 4'b0011 : 4'b1100;
            default: be = 4'b1111;
        endcase
        return be;
    endfunction

    function automatic logic [31:0] be_to_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic is_read_only(input logic [5:0] dw);
        return (dw == 6'(DW_IDS)) || (dw == 6'(DW_CLASS)) ||
               (dw == 6'(DW_SUBSYS)) || (dw == 6'(DW_ROM));
    endfunction

endpackage

// File: rtl/cfg_target_decode.sv
module cfg_target_decode
    import pcicfg_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic [31:0] addr,
    output cfg_target_t tgt,
    output logic        hit
);
    localparam logic [31:0] DEV_LIMIT = 32'(NUM_DEV);

    always_comb begin
        tgt.en    = addr[31];
        tgt.bus   = addr[23:16];
        tgt.dev   = addr[15:11];
        tgt.func  = addr[10:8];
        tgt.dword = addr[7:2];
        hit = tgt.en && (tgt.bus == 8'd0) && (tgt.func == 3'd0) &&
              ({27'd0, tgt.dev} < DEV_LIMIT);
    end
endmodule

// File: rtl/cfg_lane_path.sv
module cfg_lane_path
    import pcicfg_pkg::*;
(
    input  logic [1:0]  size,
    input  logic [1:0]  lane,
    input  logic [31:0] wdata,
    input  logic [31:0] dword_in,
    output logic [3:0]  wr_be,
    output logic [31:0] wr_aligned,
    output logic [31:0] rd_shaped
);
    logic [31:0] shifted;

    always_comb begin
        wr_be   = lane_be(size, lane);
        shifted = dword_in >> {lane, 3'b000};
        case (size)
            2'd0: begin
                wr_aligned = {24'd0, wdata[7:0]} << {lane, 3'b000};
                rd_shaped  = {24'd0, shifted[7:0]};
            end
            2'd1: begin
                wr_aligned = (lane == 2'd0) ? {16'd0, wdata[15:0]} : {wdata[15:0], 16'd0};
                rd_shaped  = (lane == 2'd0) ? {16'd0, dword_in[15:0]} : {16'd0, dword_in[31:16]};
            end
            default: begin
                wr_aligned = wdata;
                rd_shaped  = dword_in;
            end
        endcase
    end
endmodule

// File: rtl/cfg_dev_regs.sv
module cfg_dev_regs
    import pcicfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h0000,
    parameter logic [15:0] DEVICE_ID  = 16'h0000,
    parameter logic [7:0]  CLASS_CODE = 8'h00,
    parameter logic [7:0]  SUBCLASS   = 8'h00,
    parameter logic [15:0] SUBSYS_VID = 16'h0000,
    parameter logic [15:0] SUBSYS_ID  = 16'h0000,
    parameter int          BAR_CNT    = 0,
    parameter logic [5:0]  BAR_IO     = 6'b000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  idx,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    input  logic        wr_probe,
    output logic [31:0] rd_dword
);
    typedef struct packed {
        logic [HDR_DWORDS-1:0][31:0] hdr;
    } dev_state_t;

    dev_state_t st_d, st_q;

    function automatic dev_state_t reset_state();
        dev_state_t s;
        s = '0;
        for (int b = 0; b < BAR_SLOTS; b++) begin
            if (b < BAR_CNT && BAR_IO[b]) s.hdr[DW_BAR_FIRST + b] = 32'h0000_0001;
        end
        return s;
    endfunction

    logic        in_header;
    logic        is_bar;
    logic [2:0]  bar_idx;
    logic        bar_pop;
    logic        bar_io;
    logic [31:0] wr_mask;
    logic [31:0] merged;

    always_comb begin
        st_d      = st_q;
        in_header = (idx[5:4] == 2'b00);
        is_bar    = (idx >= 6'(DW_BAR_FIRST)) && (idx <= 6'(DW_BAR_LAST));
        bar_idx   = 3'(idx - 6'(DW_BAR_FIRST));
        bar_pop   = is_bar && (int'(bar_idx) < BAR_CNT);
        bar_io    = is_bar && (bar_idx < 3'(BAR_SLOTS)) && BAR_IO[bar_idx];
        wr_mask   = be_to_mask(wr_be);
        merged    = (st_q.hdr[idx[3:0]] & ~wr_mask) | (wr_data & wr_mask);
        if (is_bar && wr_probe) merged = bar_pop ? PROBE_MASK : 32'd0;
        if (bar_pop && bar_io) merged[0] = 1'b1;
        if (wr_en && in_header && !is_read_only(idx)) st_d.hdr[idx[3:0]] = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    always_comb begin
        if (!in_header) begin
            rd_dword = 32'd0;
        end else begin
            case (idx[3:0])
                4'(DW_IDS):    rd_dword = {DEVICE_ID, VENDOR_ID};
                4'(DW_CLASS):  rd_dword = {CLASS_CODE, SUBCLASS, 16'h0000};
                4'(DW_SUBSYS): rd_dword = {SUBSYS_ID, SUBSYS_VID};
                4'(DW_ROM):    rd_dword = 32'd0;
                default:       rd_dword = st_q.hdr[idx[3:0]];
            endcase
        end
    end
endmodule

// File: rtl/pci_cfg_unit.sv
module pci_cfg_unit
    import pcicfg_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter logic [NUM_DEV*16-1:0] VENDOR_IDS  = {16'h1B03, 16'h1B02, 16'h1B01, 16'h1B00},
    parameter logic [NUM_DEV*16-1:0] DEVICE_IDS  = {16'h0103, 16'h0102, 16'h0101, 16'h0100},
    parameter logic [NUM_DEV*8-1:0]  CLASS_CODES = {8'h02, 8'h01, 8'h02, 8'h06},
    parameter logic [NUM_DEV*8-1:0]  SUBCLASSES  = {8'h00, 8'h06, 8'h00, 8'h00},
    parameter logic [NUM_DEV*16-1:0] SUBSYS_VIDS = {16'h1B03, 16'h1B02, 16'h1B01, 16'h1B00},
    parameter logic [NUM_DEV*16-1:0] SUBSYS_IDS  = {16'h0004, 16'h0002, 16'h0001, 16'h0000},
    parameter logic [NUM_DEV*3-1:0]  BAR_COUNTS  = {3'd1, 3'd6, 3'd2, 3'd0},
    parameter logic [NUM_DEV*6-1:0]  BAR_IO_MAPS = {6'b000000, 6'b100000, 6'b000001, 6'b000000}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_valid,
    input  logic        io_write,
    input  logic        io_data_sel,
    input  logic [1:0]  io_lane,
    input  logic [1:0]  io_size,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata
);
    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] rdata;
    } unit_state_t;

    unit_state_t st_d, st_q;

    cfg_target_t        tgt;
    logic               tgt_hit;
    logic [31:0]        addr_q;
    logic [31:0]        dev_rd [NUM_DEV];
    logic [NUM_DEV-1:0] dev_wr;
    logic [31:0]        sel_dword;
    logic [3:0]         wr_be;
    logic [31:0]        wr_aligned;
    logic [31:0]        rd_shaped;
    logic               wr_probe;

    assign addr_q   = st_q.addr;
    assign io_rdata = st_q.rdata;
    assign wr_probe = io_size[1] && (io_wdata == ALL_ONES);

    cfg_target_decode #(.NUM_DEV(NUM_DEV)) u_decode (
        .addr (st_q.addr),
        .tgt  (tgt),
        .hit  (tgt_hit)
    );

    cfg_lane_path u_lane (
        .size       (io_size),
        .lane       (io_lane),
        .wdata      (io_wdata),
        .dword_in   (sel_dword),
        .wr_be      (wr_be),
        .wr_aligned (wr_aligned),
        .rd_shaped  (rd_shaped)
    );

    generate
        for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
            assign dev_wr[g] = io_valid && io_write && io_data_sel && tgt_hit &&
                               (tgt.dev == 5'(g));
            cfg_dev_regs #(
                .VENDOR_ID  (VENDOR_IDS[g*16 +: 16]),
                .DEVICE_ID  (DEVICE_IDS[g*16 +: 16]),
                .CLASS_CODE (CLASS_CODES[g*8 +: 8]),
                .SUBCLASS   (SUBCLASSES[g*8 +: 8]),
                .SUBSYS_VID (SUBSYS_VIDS[g*16 +: 16]),
                .SUBSYS_ID  (SUBSYS_IDS[g*16 +: 16]),
                .BAR_CNT    (int'(BAR_COUNTS[g*3 +: 3])),
                .BAR_IO     (BAR_IO_MAPS[g*6 +: 6])
            ) u_regs (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (dev_wr[g]),
                .idx      (tgt.dword),
                .wr_be    (wr_be),
                .wr_data  (wr_aligned),
                .wr_probe (wr_probe),
                .rd_dword (dev_rd[g])
            );
        end
    endgenerate

    always_comb begin
        sel_dword = 32'd0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (tgt.dev == 5'(i)) sel_dword = dev_rd[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (io_valid && io_write && !io_data_sel) st_d.addr = io_wdata;
        if (io_valid && !io_write) begin
            if (!io_data_sel)  st_d.rdata = st_q.addr;
            else if (!tgt_hit) st_d.rdata = ALL_ONES;
            else               st_d.rdata = rd_shaped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pci_cfg_unit_chk.sv
module pci_cfg_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_valid,
    input logic        io_write,
    input logic        io_data_sel,
    input logic [1:0]  io_size,
    input logic [31:0] io_wdata,
    input logic [31:0] io_rdata,
    input logic [31:0] addr_q,
    input logic        tgt_hit
);
    logic rd_acc;
    assign rd_acc = io_valid && !io_write;

    assert_addr_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid && io_write && !io_data_sel |=> addr_q == $past(io_wdata));

    assert_addr_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc && !io_data_sel |=> io_rdata == $past(addr_q));

    assert_disabled_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc && io_data_sel && !addr_q[31] |=> io_rdata == 32'hFFFF_FFFF);

    assert_bad_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc && io_data_sel && !tgt_hit |=> io_rdata == 32'hFFFF_FFFF);

    assert_byte_zext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc && io_data_sel && tgt_hit && io_size == 2'd0 |=> io_rdata[31:8] == 24'd0);

    assert_half_zext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc && io_data_sel && tgt_hit && io_size == 2'd1 |=> io_rdata[31:16] == 16'd0);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(io_rdata));
endmodule

bind pci_cfg_unit pci_cfg_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_valid    (io_valid),
    .io_write    (io_write),
    .io_data_sel (io_data_sel),
    .io_size     (io_size),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .addr_q      (addr_q),
    .tgt_hit     (tgt_hit)
);

// File: tb/pci_cfg_unit_tb.sv
module pci_cfg_unit_tb;
    localparam int NDEV = 4;
    localparam logic [63:0] VIDS = {16'h1B03, 16'h1B02, 16'h1B01, 16'h1B00};
    localparam logic [63:0] DIDS = {16'h0103, 16'h0102, 16'h0101, 16'h0100};
    localparam logic [31:0] CLS  = {8'h02, 8'h01, 8'h02, 8'h06};
    localparam logic [31:0] SUBC = {8'h00, 8'h06, 8'h00, 8'h00};
    localparam logic [63:0] SVID = {16'h1B03, 16'h1B02, 16'h1B01, 16'h1B00};
    localparam logic [63:0] SSID = {16'h0004, 16'h0002, 16'h0001, 16'h0000};
    localparam logic [11:0] BCNT = {3'd1, 3'd6, 3'd2, 3'd0};
    localparam logic [23:0] BIO  = {6'b000000, 6'b100000, 6'b000001, 6'b000000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_valid = 1'b0, io_write = 1'b0, io_data_sel = 1'b0;
    logic [1:0] io_lane = 2'd0, io_size = 2'd2;
    logic [31:0] io_wdata = 32'd0;
    logic [31:0] io_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_addr;
    logic [31:0] m_rdata;
    logic [31:0] m_hdr [NDEV][16];

    always #4 clk = ~clk;

    pci_cfg_unit #(
        .NUM_DEV(NDEV), .VENDOR_IDS(VIDS), .DEVICE_IDS(DIDS), .CLASS_CODES(CLS),
        .SUBCLASSES(SUBC), .SUBSYS_VIDS(SVID), .SUBSYS_IDS(SSID),
        .BAR_COUNTS(BCNT), .BAR_IO_MAPS(BIO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_data_sel(io_data_sel), .io_lane(io_lane), .io_size(io_size),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic bit hit_f(logic [31:0] a);
        return a[31] && a[23:16] == 8'd0 && a[10:8] == 3'd0 && int'(a[15:11]) < NDEV;
    endfunction

    function automatic logic [31:0] hdr_value(int d, int w);
        if (w >= 16) return 32'd0;
        case (w)
            0:  return {DIDS[d*16 +: 16], VIDS[d*16 +: 16]};
            2:  return {CLS[d*8 +: 8], SUBC[d*8 +: 8], 16'h0000};
            11: return {SSID[d*16 +: 16], SVID[d*16 +: 16]};
            12: return 32'd0;
            default: return m_hdr[d][w];
        endcase
    endfunction

    function automatic logic [31:0] model_read(logic [1:0] size, logic [1:0] lane);
        logic [31:0] dw;
        if (!hit_f(m_addr)) return 32'hFFFF_FFFF;
        dw = hdr_value(int'(m_addr[15:11]), int'(m_addr[7:2]));
        if (size == 2'd0) return {24'd0, dw[lane*8 +: 8]};
        if (size == 2'd1) return (lane == 2'd0) ? {16'd0, dw[15:0]} : {16'd0, dw[31:16]};
        return dw;
    endfunction

    function automatic void model_write(logic [1:0] size, logic [1:0] lane, logic [31:0] wd);
        int d, w, b;
        logic [31:0] mask, al, merged;
        if (!hit_f(m_addr)) return;
        d = int'(m_addr[15:11]);
        w = int'(m_addr[7:2]);
        if (w >= 16 || w == 0 || w == 2 || w == 11 || w == 12) return;
        if (size == 2'd0) begin
            mask = 32'hFF << (lane * 8); al = {24'd0, wd[7:0]} << (lane * 8);
        end else if (size == 2'd1) begin
            mask = (lane == 2'd0) ? 32'h0000_FFFF : 32'hFFFF_0000;
            al   = (lane == 2'd0) ? {16'd0, wd[15:0]} : {wd[15:0], 16'd0};
        end else begin
            mask = 32'hFFFF_FFFF; al = wd;
        end
        merged = (m_hdr[d][w] & ~mask) | (al & mask);
        if (w >= 4 && w <= 9) begin
            b = w - 4;
            if (size[1] && wd == 32'hFFFF_FFFF)
                merged = (b < int'(BCNT[d*3 +: 3])) ? 32'hFFFF_F000 : 32'd0;
            if (b < int'(BCNT[d*3 +: 3]) && BIO[d*6 + b]) merged[0] = 1'b1;
        end
        m_hdr[d][w] = merged;
    endfunction

    function automatic string tag_for(logic [1:0] size);
        int w;
        if (!m_addr[31]) return "R3";
        if (!hit_f(m_addr)) return "R4";
        w = int'(m_addr[7:2]);
        if (w == 0 || w == 2 || w == 11) return "R5";
        if (w >= 4 && w <= 9) return "R6";
        if (w == 12) return "R8";
        if (size != 2'd2 && size != 2'd3) return "R10";
        return "R9";
    endfunction

    task automatic acc(bit dsel, bit wr, logic [1:0] size, logic [1:0] lane,
                       logic [31:0] wd, string tag);
        logic [31:0] exp;
        exp = dsel ? model_read(size, lane) : m_addr;
        @(negedge clk);
        io_valid = 1'b1; io_write = wr; io_data_sel = dsel;
        io_size = size; io_lane = lane; io_wdata = wd;
        @(negedge clk);
        io_valid = 1'b0;
        if (!wr) begin
            check(tag, io_rdata, exp);
            m_rdata = exp;
        end else if (dsel) begin
            model_write(size, lane, wd);
        end else begin
            m_addr = wd;
        end
    endtask

    function automatic logic [31:0] mk_addr(int dev, int dw);
        return 32'h8000_0000 | (32'(dev) << 11) | (32'(dw) << 2);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_addr = 32'd0; m_rdata = 32'd0;
        for (int d = 0; d < NDEV; d++)
            for (int w = 0; w < 16; w++)
                m_hdr[d][w] = (w >= 4 && w <= 9 && (w - 4) < int'(BCNT[d*3 +: 3]) &&
                               BIO[d*6 + w - 4]) ? 32'h1 : 32'h0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset rdata", io_rdata, 32'd0);
        acc(0, 0, 2'd2, 2'd0, 0, "R1 reset addr");

        // identification dwords and read-only behavior
        acc(0, 1, 2'd2, 2'd0, mk_addr(0, 0), "R1");
        acc(0, 0, 2'd2, 2'd0, 0, "R1 readback");
        acc(1, 0, 2'd2, 2'd0, 0, "R5 ids");
        acc(1, 1, 2'd2, 2'd0, 32'h1234_5678, "R5");
        acc(1, 0, 2'd2, 2'd0, 0, "R5 ids after write");
        acc(0, 1, 2'd2, 2'd0, mk_addr(2, 11), "R5");
        acc(1, 0, 2'd2, 2'd0, 0, "R5 subsys");

        // disabled address: read all ones, write ignored
        acc(0, 1, 2'd2, 2'd0, mk_addr(1, 4) & 32'h7FFF_FFFF, "R3");
        acc(1, 1, 2'd2, 2'd0, 32'h0000_1230, "R3");
        acc(1, 0, 2'd2, 2'd0, 0, "R3 disabled read");
        acc(0, 1, 2'd2, 2'd0, mk_addr(1, 4), "R3");
        acc(1, 0, 2'd2, 2'd0, 0, "R3 write ignored / R7 reset io bit");

        // BAR probes
        acc(1, 1, 2'd2, 2'd0, 32'hFFFF_FFFF, "R6");
        acc(1, 0, 2'd2, 2'd0, 0, "R6 R7 io probe");
        acc(1, 1, 2'd2, 2'd0, 32'h0000_ABC0, "R7");
        acc(1, 0, 2'd2, 2'd0, 0, "R7 io bit forced");
        acc(0, 1, 2'd2, 2'd0, mk_addr(1, 5), "R6");
        acc(1, 1, 2'd2, 2'd0, 32'hFFFF_FFFF, "R6");
        acc(1, 0, 2'd2, 2'd0, 0, "R6 mem probe");
        acc(0, 1, 2'd2, 2'd0, mk_addr(1, 6), "R6");
        acc(1, 1, 2'd2, 2'd0, 32'hFFFF_FFFF, "R6");
        acc(1, 0, 2'd2, 2'd0, 0, "R6 unpopulated probe");

        // expansion ROM
        acc(0, 1, 2'd2, 2'd0, mk_addr(1, 12), "R8");
        acc(1, 1, 2'd2, 2'd0, 32'hDEAD_BEEF, "R8");
        acc(1, 0, 2'd2, 2'd0, 0, "R8 rom dropped");

        // invalid targets
        acc(0, 1, 2'd2, 2'd0, mk_addr(3, 1), "R2");
        acc(1, 1, 2'd2, 2'd0, 32'h5555_5555, "R2");
        acc(0, 1, 2'd2, 2'd0, mk_addr(2, 1), "R2");
        acc(1, 0, 2'd2, 2'd0, 0, "R2 device select");
        acc(0, 1, 2'd2, 2'd0, mk_addr(5, 1), "R4");
        acc(1, 0, 2'd2, 2'd0, 0, "R4 device beyond count");
        acc(0, 1, 2'd2, 2'd0, mk_addr(0, 1) | 32'h0000_0100, "R4");
        acc(1, 0, 2'd2, 2'd0, 0, "R4 function nonzero");
        acc(0, 1, 2'd2, 2'd0, mk_addr(0, 1) | 32'h0001_0000, "R4");
        acc(1, 1, 2'd2, 2'd0, 32'h7777_7777, "R4");
        acc(1, 0, 2'd2, 2'd0, 0, "R4 bus nonzero");

        // lanes
        acc(0, 1, 2'd2, 2'd0, mk_addr(2, 15), "R9");
        acc(1, 1, 2'd2, 2'd0, 32'h1122_3344, "R9");
        acc(1, 0, 2'd0, 2'd2, 0, "R10 byte lane 2");
        acc(1, 0, 2'd1, 2'd2, 0, "R10 half upper");
        acc(1, 0, 2'd1, 2'd0, 0, "R10 half lower");
        acc(1, 1, 2'd0, 2'd1, 32'h0000_00AA, "R9");
        acc(1, 0, 2'd2, 2'd0, 0, "R9 byte merge");
        acc(1, 1, 2'd1, 2'd3, 32'h0000_BEEF, "R9");
        acc(1, 0, 2'd2, 2'd0, 0, "R9 half merge");
        acc(0, 1, 2'd2, 2'd0, mk_addr(2, 20), "R9");
        acc(1, 1, 2'd2, 2'd0, 32'hCAFE_F00D, "R9");
        acc(1, 0, 2'd2, 2'd0, 0, "R9 beyond header");
        acc(1, 1, 2'd2, 2'd0, 32'h1, "R11");
        check("R11 hold after write", io_rdata, m_rdata);

        // random traffic
        for (int it = 0; it < 600; it++) begin
            logic [31:0] a;
            int dw;
            dw = ($urandom % 8 == 0) ? 16 + int'($urandom % 8) : int'($urandom % 16);
            a = mk_addr(int'($urandom % 6), dw);
            if ($urandom % 12 == 0) a[31] = 1'b0;
            if ($urandom % 10 == 0) a[23:16] = 8'(1 + $urandom % 3);
            if ($urandom % 10 == 0) a[10:8] = 3'(1 + $urandom % 7);
            acc(0, 1, 2'd2, 2'd0, a, "R1");
            if ($urandom % 8 == 0) acc(0, 0, 2'd2, 2'd0, 0, "R1 random readback");
            for (int k = 0; k < 3; k++) begin
                logic [1:0] sz, ln;
                logic [31:0] wd;
                sz = 2'($urandom % 4);
                ln = 2'($urandom % 4);
                wd = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
                if ($urandom % 2 == 0) begin
                    acc(1, 1, sz, ln, wd, "R9");
                    check("R11 hold random", io_rdata, m_rdata);
                end else begin
                    acc(1, 0, sz, ln, 0, tag_for(sz));
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule